// File: doc/BRIEF.md
# Leading-One Normalizer with Denormal Clamp

This block takes an unnormalized extended-format value, made of a 16-bit biased exponent and a 64-bit mantissa with an explicit integer bit, and moves the first set mantissa bit up to the most significant position. For every position the mantissa moves left, the exponent drops by one. The leading-zero count is taken from the upper 32-bit word. Only when that word is empty does the count come from the lower word, plus 32. A barrel shifter then moves the whole 64-bit mantissa, so bits leaving the lower word enter the bottom of the upper word and zeros fill in from the right.

A mode input selects between two behaviours. In clamped mode the exponent never goes below zero. If the leading-zero count is larger than the exponent, the mantissa moves left only by the exponent value and the exponent becomes zero, which leaves a denormal. In free mode the full normalizing shift is always applied and the exponent wraps modulo 2^16. In both modes an all-zero mantissa gives an exponent of zero.

The datapath is one combinational stage followed by an output register. A valid strobe travels with the data and arrives one cycle later. While the strobe is low, the output register keeps its contents.

Top module: `lead_one_normalizer`

## Requirements
- R1: When the upper 32 mantissa bits are all zero, the leading-zero count is 32 plus the count found in the lower word, and the shift and the exponent reduction both use that total.
- R2: A nonzero mantissa whose leading-zero count k does not exceed the limit is shifted left by k, and the exponent is reduced by k. With k = 0 the mantissa and the exponent pass through unchanged.
- R3: In clamped mode (`norm_clamp` = 1), when the exponent is below 64 and k is greater than the exponent e, the mantissa is shifted left by e and the output exponent is 0.
- R4: In clamped mode, an exponent of 64 or more always receives the full normalizing shift by k.
- R5: An all-zero mantissa produces exponent 0 and mantissa 0 in either mode.
- R6: The shift keeps every set mantissa bit. Bits from the lower word move into the upper word, and zeros enter from the least significant end, so the count of ones is preserved.
- R7: In free mode (`norm_clamp` = 0), the shift is always by k and the exponent becomes (e - k) modulo 2^16.
- R8: `out_valid` equals the `in_valid` of the previous cycle, and the result of an accepted input appears on the outputs one cycle after acceptance.
- R9: When `in_valid` is low, `out_exp` and `out_mant` keep their previous values.
- R10: A synchronous active-low reset clears `out_valid`, `out_exp` and `out_mant` to zero.
- R11: In clamped mode with k equal to e (e below 64), the mantissa becomes fully normalized and the exponent becomes exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operand is present |
| norm_clamp | input | 1 | 1 = clamp at exponent zero, 0 = free normalization |
| in_exp | input | 16 | Biased exponent, unsigned |
| in_mant | input | 64 | Mantissa, bit 63 is the integer bit |
| out_valid | output | 1 | Registered result is present |
| out_exp | output | 16 | Result exponent |
| out_mant | output | 64 | Result mantissa |

## Verification
The hardest case to reach is the boundary where the clamp only just engages. This needs an operand whose leading-zero count equals its exponent, or is one greater, and the count must fall in the lower word, so that the upper-word count, the half-combining adder and the exponent comparison are all exercised together. The vector table sets exponents of 0, 3, 5, 63 and 64 against mantissas whose first one sits in either word. Free-mode vectors repeat the same patterns, so the wrapped exponent and the clamped result can be told apart.

// File: rtl/norm_pkg.sv
// Shared sizes and mode encoding for the leading-one normalizer.
// Assumes the mantissa splits into two equal power-of-two halves.
package norm_pkg;
    localparam int NORM_EXP_W  = 16;
    localparam int NORM_MANT_W = 64;

    typedef enum logic {
        MODE_FREE  = 1'b0,
        MODE_CLAMP = 1'b1
    } norm_mode_e;
endpackage

// File: rtl/lzc_half.sv
// Leading-zero counter for one mantissa word.
// Output cnt is W when the word is all zero. Purely combinational.
module lzc_half #(
    parameter int W     = 32,
    localparam int CW   = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt,
    output logic          all_zero
);
    // Scan from LSB upward so the highest set bit gives the final count
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end

    // Flag an empty word
    assign all_zero = ~|vec;
endmodule

// File: rtl/lzc_wide.sv
// Full-width leading-zero counter built from two half-word counters.
// The upper half wins. When it is empty, the lower count is added to HALF.
module lzc_wide #(
    parameter int W     = 64,
    localparam int HALF = W / 2,
    localparam int HCW  = $clog2(HALF) + 1,
    localparam int CW   = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt,
    output logic          all_zero
);
    logic [HCW-1:0] part_cnt  [2];
    logic           part_zero [2];

    // One counter per half word; index 1 is the upper half
    for (genvar g = 0; g < 2; g++) begin : g_half
        lzc_half #(.W(HALF)) u_half (
            .vec      (vec[g*HALF +: HALF]),
            .cnt      (part_cnt[g]),
            .all_zero (part_zero[g])
        );
    end

    // Merge the two half counts with upper-word priority
    always_comb begin
        if (part_zero[1]) cnt = CW'(HALF) + CW'(part_cnt[0]);
        else              cnt = CW'(part_cnt[1]);
    end

    assign all_zero = part_zero[0] & part_zero[1];
endmodule

// File: rtl/shl_barrel.sv
// Logarithmic left shifter, zero filled from the LSB side.
// One mux stage per amount bit. Shift amounts up to W-1 only.
module shl_barrel #(
    parameter int W     = 64,
    localparam int AW   = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  result
);
    logic [W-1:0] stage [AW+1];

    assign stage[0] = data;

    // Each stage conditionally shifts by a power of two
    for (genvar s = 0; s < AW; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign result = stage[AW];
endmodule

// File: rtl/lead_one_normalizer.sv
// Normalizes an exponent/mantissa pair by moving the leading one to the MSB.
// Clamped mode stops the exponent at zero, leaving a denormal. Free mode
// wraps the exponent. A zero mantissa gives exponent zero. One register stage.
// Assumes EXP_W is wider than the shift count and can hold MANT_W.
module lead_one_normalizer
    import norm_pkg::*;
#(
    parameter int EXP_W  = NORM_EXP_W,
    parameter int MANT_W = NORM_MANT_W,
    localparam int CW    = $clog2(MANT_W) + 1,
    localparam int AW    = $clog2(MANT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              norm_clamp,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant
);
    localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'(MANT_W);

    norm_mode_e         mode;
    logic [CW-1:0]      lz;
    logic               mant_zero;
    logic [EXP_W-1:0]   lz_ext;
    logic               clamp_hit;
    logic [AW-1:0]      shift_amt;
    logic [MANT_W-1:0]  shifted;
    logic [EXP_W-1:0]   exp_next;

    assign mode   = norm_mode_e'(norm_clamp);
    assign lz_ext = EXP_W'(lz);

    lzc_wide #(.W(MANT_W)) u_lzc (
        .vec      (in_mant),
        .cnt      (lz),
        .all_zero (mant_zero)
    );

    // Decide whether the exponent limits the shift
    always_comb begin
        clamp_hit = (mode == MODE_CLAMP) && (in_exp < EXP_LIMIT) && (lz_ext > in_exp);
    end

    // Pick the shift distance and the new exponent
    always_comb begin
        if (mant_zero) begin
            shift_amt = '0;
            exp_next  = '0;
        end else if (clamp_hit) begin
            shift_amt = in_exp[AW-1:0];
            exp_next  = '0;
        end else begin
            shift_amt = lz[AW-1:0];
            exp_next  = in_exp - lz_ext;
        end
    end

    shl_barrel #(.W(MANT_W)) u_shift (
        .data   (in_mant),
        .amt    (shift_amt),
        .result (shifted)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_exp   <= '0;
            out_mant  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_exp  <= exp_next;
                out_mant <= shifted;
            end
        end
    end
endmodule

// File: rtl/lead_one_normalizer_checker.sv
// Temporal checks on the normalizer ports, attached by bind.
module lead_one_normalizer_checker #(
    parameter int EXP_W  = 16,
    parameter int MANT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              norm_clamp,
    input logic [EXP_W-1:0]  in_exp,
    input logic [MANT_W-1:0] in_mant,
    input logic              out_valid,
    input logic [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0] out_mant
);
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_exp == '0 && out_mant == '0));

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_exp) && $stable(out_mant)));

    p_zero_mant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant == '0) |=> (out_exp == '0 && out_mant == '0));

    p_ones_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(out_mant) == $past($countones(in_mant))));

    p_norm_or_denorm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && norm_clamp && in_mant != '0) |=> (out_mant[MANT_W-1] || out_exp == '0));

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && norm_clamp) |=> (out_exp <= $past(in_exp)));

    p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant[MANT_W-1]) |=> (out_exp == $past(in_exp) && out_mant == $past(in_mant)));

    p_free_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !norm_clamp && in_mant != '0) |=> out_mant[MANT_W-1]);
endmodule

bind lead_one_normalizer lead_one_normalizer_checker #(
    .EXP_W  (EXP_W),
    .MANT_W (MANT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .norm_clamp (norm_clamp),
    .in_exp     (in_exp),
    .in_mant    (in_mant),
    .out_valid  (out_valid),
    .out_exp    (out_exp),
    .out_mant   (out_mant)
);

// File: tb/lead_one_normalizer_bench.sv
// Vector-table bench for the leading-one normalizer.
module lead_one_normalizer_bench;
    localparam int NV  = 13;
    localparam int VW  = 1 + 16 + 64 + 16 + 64;

    // {clamp, exp_in, mant_in, exp_expected, mant_expected}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 16'h4000, 64'h0000_0001_0000_0000, 16'h3FE1, 64'h8000_0000_0000_0000}, // R2
        {1'b1, 16'h4000, 64'h0000_0000_0000_0010, 16'h3FC5, 64'h8000_0000_0000_0000}, // R1
        {1'b1, 16'h0005, 64'h0000_0100_0000_0000, 16'h0000, 64'h0000_2000_0000_0000}, // R3
        {1'b1, 16'h0040, 64'h0000_0000_0000_0001, 16'h0001, 64'h8000_0000_0000_0000}, // R4
        {1'b1, 16'h0003, 64'h1234_5678_9ABC_DEF0, 16'h0000, 64'h91A2_B3C4_D5E6_F780}, // R11
        {1'b1, 16'h0100, 64'h0000_0003_FFFF_FFFF, 16'h00E2, 64'hFFFF_FFFF_C000_0000}, // R6
        {1'b0, 16'h0002, 64'h0000_0000_0000_0001, 16'hFFC3, 64'h8000_0000_0000_0000}, // R7
        {1'b1, 16'h1234, 64'h0000_0000_0000_0000, 16'h0000, 64'h0000_0000_0000_0000}, // R5
        {1'b0, 16'h7FFF, 64'h0000_0000_0000_0000, 16'h0000, 64'h0000_0000_0000_0000}, // R5
        {1'b1, 16'h0000, 64'h8000_0000_0000_0001, 16'h0000, 64'h8000_0000_0000_0001}, // R2
        {1'b1, 16'h0000, 64'h0000_0000_0000_00FF, 16'h0000, 64'h0000_0000_0000_00FF}, // R3
        {1'b0, 16'h0005, 64'h0000_0100_0000_0000, 16'hFFEE, 64'h8000_0000_0000_0000}, // R7
        {1'b1, 16'h003F, 64'h0000_0000_0000_0001, 16'h0000, 64'h8000_0000_0000_0000}  // R11
    };
    string tags [NV] = '{"R2", "R1", "R3", "R4", "R11", "R6", "R7",
                         "R5", "R5", "R2", "R3", "R7", "R11"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        norm_clamp = 1'b0;
    logic [15:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic        out_valid;
    logic [15:0] out_exp;
    logic [63:0] out_mant;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lead_one_normalizer u_lead_one_normalizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .norm_clamp (norm_clamp),
        .in_exp     (in_exp),
        .in_mant    (in_mant),
        .out_valid  (out_valid),
        .out_exp    (out_exp),
        .out_mant   (out_mant)
    );

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {out_exp, out_mant}, 80'h0);
        check("R10", {79'h0, out_valid}, 80'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            norm_clamp = VEC[i][VW-1];
            in_exp     = VEC[i][VW-2 -: 16];
            in_mant    = VEC[i][VW-18 -: 64];
            @(negedge clk);
            in_valid = 1'b0;
            check(tags[i], {out_exp, out_mant}, VEC[i][79:0]);
            check("R8", {79'h0, out_valid}, 80'h1);
        end

        // R9: idle input with different data leaves outputs alone
        in_exp  = 16'h1111;
        in_mant = 64'h0000_0000_0000_0003;
        @(negedge clk);
        check("R9", {out_exp, out_mant}, {16'h0000, 64'h8000_0000_0000_0000});
        check("R8", {79'h0, out_valid}, 80'h0);

        // R10: reset mid-run after a loaded result
        in_valid   = 1'b1;
        norm_clamp = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", {out_exp, out_mant}, {16'h10D3, 64'hC000_0000_0000_0000});
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {out_exp, out_mant}, 80'h0);
        check("R10", {79'h0, out_valid}, 80'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule